// File: doc/BRIEF.md
# Floating-Point Issue and Writeback Timing Controller

This block decides when an operation may leave the dispatch stage of a floating-point pipeline and signals, at the right cycle, when that operation writes back. It carries no arithmetic. Each accepted operation becomes a token holding its destination register and its operation class. The token moves through a timing pipe and comes out on the writeback strobe after the latency that belongs to its class.

Dispatch is held for two reasons. The first is an operand hazard: a source or destination register still waits for an older result, as recorded in a pending-register scoreboard. The second is a structural hazard on the single writeback slot. Compare-type operations finish sooner than ordinary arithmetic, so a young compare can land on the same cycle as an older arithmetic operation. Divides are not pipelined. A divide holds the writeback slot for many cycles, and no other operation may arrive there during that time. A reservation window of future writeback cycles resolves both cases at dispatch. Once a token is accepted it never stalls.

Top module: `fpq_issue_ctl`

## Requirements
- R1: After synchronous reset, `wb_valid` is 0, no register is pending, and `disp_ready` is 1 for any presented request.
- R2: Class code 0 (arithmetic/move) and class code 2 (fused multiply-add) accepted in cycle c raise `wb_valid` in cycle c+5 with the same destination and class.
- R3: Class code 1 (condition-register update / compare) accepted in cycle c raises `wb_valid` in cycle c+2.
- R4: Class code 3 (single divide) reaches writeback in cycle c+5, holds the writeback slot for 13 cycles (c+5 to c+17), and raises `wb_valid` only in cycle c+17.
- R5: Class code 4 (double divide) holds the writeback slot for 25 cycles (c+5 to c+29) and raises `wb_valid` only in cycle c+29.
- R6: `disp_ready` is 0 while source A or source B is pending. Source C is checked only for class 2 and is ignored for every other class.
- R7: `disp_ready` is 0 while the destination register is pending.
- R8: A register becomes pending in the cycle after its operation is accepted. It stops being pending in the cycle after its `wb_valid`. A request that reads it during the `wb_valid` cycle is still held.
- R9: `disp_ready` is 0 when any cycle of the request's writeback window (one cycle, or the whole divide occupancy) is already reserved, so at most one operation is in writeback at any time.
- R10: Class codes 5, 6 and 7 behave as class 0 and are reported with class 0 on `wb_cls`.
- R11: A request with `disp_valid` low is not accepted and never produces a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_cls | input | 3 | Operation class code |
| disp_dst | input | 5 | Destination register index |
| disp_srca | input | 5 | First source register index |
| disp_srcb | input | 5 | Second source register index |
| disp_srcc | input | 5 | Third source register index (fused multiply-add only) |
| disp_ready | output | 1 | Request may leave dispatch this cycle |
| wb_valid | output | 1 | Writeback strobe |
| wb_dst | output | 5 | Destination index of the writing operation |
| wb_cls | output | 3 | Normalised class of the writing operation |

## Verification
The bench targets a compare issued three cycles after an arithmetic operation. A design without writeback reservation would let both tokens reach writeback in the same cycle, and one result would be lost. It issues arithmetic right behind single and double divides. A design whose occupancy is off by one would strobe a cycle early or late, or would let the follower in while the divide still holds writeback. It also reads a register during its own writeback cycle, where a design that clears pending state too early would accept the request. A third source that is busy on a non-multiply-add operation must not stall it. Class codes 5 to 7 must come out as plain arithmetic.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;

    typedef enum logic [2:0] {
        CLS_ARITH = 3'd0,
        CLS_CMP   = 3'd1,
        CLS_FMA   = 3'd2,
        CLS_DIVS  = 3'd3,
        CLS_DIVD  = 3'd4
    } fpq_cls_e;

    typedef struct packed {
        logic              vld;
        logic [RIDX_W-1:0] dst;
        fpq_cls_e          cls;
    } fpq_tok_t;

    // Raw code to class; unused codes fall back to plain arithmetic.
    function automatic fpq_cls_e fpq_norm(input logic [2:0] code);
        return (code > 3'd4) ? CLS_ARITH : fpq_cls_e'(code);
    endfunction

    // Cycles from acceptance until the token first enters writeback.
    function automatic int fpq_lat(input fpq_cls_e c, input int lat_arith, input int lat_cmp);
        return (c == CLS_CMP) ? lat_cmp : lat_arith;
    endfunction

    // Cycles the token holds the writeback slot.
    function automatic int fpq_occ(input fpq_cls_e c, input int occ_s, input int occ_d);
        case (c)
            CLS_DIVS: return occ_s;
            CLS_DIVD: return occ_d;
            default:  return 1;
        endcase
    endfunction

    function automatic logic fpq_reads_c(input fpq_cls_e c);
        return c == CLS_FMA;
    endfunction

endpackage

// File: rtl/fpq_scoreboard.sv
module fpq_scoreboard
    import fpq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [RIDX_W-1:0] set_idx,
    input  logic              clr_en,
    input  logic [RIDX_W-1:0] clr_idx,
    output logic [NREG-1:0]   busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
        end else begin
            if (clr_en) busy[clr_idx] <= 1'b0;
            if (set_en) busy[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/fpq_wb_reserve.sv
module fpq_wb_reserve #(
    parameter int RES_W = 30,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] lat,
    input  logic [CW-1:0] occ,
    input  logic          take,
    output logic          conflict
);
    // Bit j set: the writeback slot is owned j cycles from now.
    logic [RES_W-1:0] resv;
    logic [RES_W-1:0] want;

    always_comb begin
        for (int i = 0; i < RES_W; i++) begin
            want[i] = (i >= int'(lat)) && (i < int'(lat) + int'(occ));
        end
    end

    assign conflict = |(resv & want);

    always_ff @(posedge clk) begin
        if (rst) resv <= '0;
        else     resv <= (resv | (take ? want : '0)) >> 1;
    end
endmodule

// File: rtl/fpq_pipe.sv
module fpq_pipe
    import fpq_pkg::*;
#(
    parameter int LAT_ARITH = 5,
    parameter int OCC_DS    = 13,
    parameter int OCC_DD    = 25,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_en,
    input  logic [CW-1:0] ins_lat,
    input  fpq_tok_t      ins_tok,
    output logic          wb_valid,
    output fpq_tok_t      wb_tok,
    output logic          hold_busy,
    output logic          tail_vld
);
    localparam int DEPTH = LAT_ARITH - 1;
    localparam int CNT_W = $clog2(OCC_DD + 1);

    fpq_tok_t         stg [DEPTH];
    fpq_tok_t         wb_q;
    logic [CNT_W-1:0] hold_cnt;
    int               ins_pos;

    assign ins_pos = LAT_ARITH - int'(ins_lat);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)                         stg[g] <= '0;
            else if (ins_en && ins_pos == g) stg[g] <= ins_tok;
            else if (g == 0)                 stg[g] <= '0;
            else                             stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q     <= '0;
            hold_cnt <= '0;
        end else if (wb_q.vld && hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else begin
            wb_q     <= stg[DEPTH-1];
            hold_cnt <= CNT_W'(fpq_occ(stg[DEPTH-1].cls, OCC_DS, OCC_DD) - 1);
        end
    end

    assign wb_valid  = wb_q.vld && hold_cnt == '0;
    assign wb_tok    = wb_q;
    assign hold_busy = wb_q.vld && hold_cnt != '0;
    assign tail_vld  = stg[DEPTH-1].vld;
endmodule

// File: rtl/fpq_issue_ctl.sv
module fpq_issue_ctl
    import fpq_pkg::*;
#(
    parameter int LAT_ARITH = 5,
    parameter int LAT_CMP   = 2,
    parameter int OCC_DS    = 13,
    parameter int OCC_DD    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [2:0]        disp_cls,
    input  logic [RIDX_W-1:0] disp_dst,
    input  logic [RIDX_W-1:0] disp_srca,
    input  logic [RIDX_W-1:0] disp_srcb,
    input  logic [RIDX_W-1:0] disp_srcc,
    output logic              disp_ready,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_dst,
    output logic [2:0]        wb_cls
);
    localparam int RES_W = LAT_ARITH + OCC_DD;
    localparam int CW    = $clog2(RES_W + 1);

    fpq_cls_e       req_cls;
    logic [CW-1:0]  req_lat, req_occ;
    logic           src_hit, dst_hit, slot_hit, accept;
    logic [NREG-1:0] sb_busy;
    fpq_tok_t       req_tok, out_tok;
    logic           hold_busy, tail_vld;

    assign req_cls = fpq_norm(disp_cls);
    assign req_lat = CW'(fpq_lat(req_cls, LAT_ARITH, LAT_CMP));
    assign req_occ = CW'(fpq_occ(req_cls, OCC_DS, OCC_DD));

    assign src_hit = sb_busy[disp_srca] | sb_busy[disp_srcb]
                   | (fpq_reads_c(req_cls) & sb_busy[disp_srcc]);
    assign dst_hit = sb_busy[disp_dst];

    assign disp_ready = !src_hit && !dst_hit && !slot_hit;
    assign accept     = disp_valid && disp_ready;

    assign req_tok = '{vld: 1'b1, dst: disp_dst, cls: req_cls};

    fpq_scoreboard u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept),
        .set_idx (disp_dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_dst),
        .busy    (sb_busy)
    );

    fpq_wb_reserve #(.RES_W(RES_W), .CW(CW)) u_resv (
        .clk      (clk),
        .rst      (rst),
        .lat      (req_lat),
        .occ      (req_occ),
        .take     (accept),
        .conflict (slot_hit)
    );

    fpq_pipe #(
        .LAT_ARITH (LAT_ARITH),
        .OCC_DS    (OCC_DS),
        .OCC_DD    (OCC_DD),
        .CW        (CW)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .ins_en    (accept),
        .ins_lat   (req_lat),
        .ins_tok   (req_tok),
        .wb_valid  (wb_valid),
        .wb_tok    (out_tok),
        .hold_busy (hold_busy),
        .tail_vld  (tail_vld)
    );

    assign wb_dst = out_tok.dst;
    assign wb_cls = out_tok.cls;
endmodule

// File: rtl/fpq_issue_chk.sv
module fpq_issue_chk
    import fpq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [RIDX_W-1:0] disp_dst,
    input logic [RIDX_W-1:0] disp_srca,
    input logic [RIDX_W-1:0] disp_srcb,
    input logic              wb_valid,
    input logic [RIDX_W-1:0] wb_dst,
    input logic [NREG-1:0]   busy,
    input logic              hold_busy,
    input logic              tail_vld
);
    // R1: the first cycle after reset has no writeback
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wb_valid && busy == '0);

    // R6: busy source holds dispatch
    a_r6_src_stall: assert property (@(posedge clk) disable iff (rst)
        (busy[disp_srca] || busy[disp_srcb]) |-> !disp_ready);

    // R7: busy destination holds dispatch
    a_r7_dst_stall: assert property (@(posedge clk) disable iff (rst)
        busy[disp_dst] |-> !disp_ready);

    // R8: accepted destination becomes pending next cycle
    a_r8_set_on_accept: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> busy[$past(disp_dst)]);

    // R8: writeback frees its register next cycle
    a_r8_clear_on_wb: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !busy[$past(wb_dst)]);

    // R9: nothing queues behind a divide holding writeback
    a_r9_no_collision: assert property (@(posedge clk) disable iff (rst)
        hold_busy |-> !tail_vld);
endmodule

bind fpq_issue_ctl fpq_issue_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_dst   (disp_dst),
    .disp_srca  (disp_srca),
    .disp_srcb  (disp_srcb),
    .wb_valid   (wb_valid),
    .wb_dst     (wb_dst),
    .busy       (sb_busy),
    .hold_busy  (hold_busy),
    .tail_vld   (tail_vld)
);

// File: tb/sim_fpq_issue_ctl.sv
module sim_fpq_issue_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disp_valid = 1'b0;
    logic [2:0] disp_cls = '0;
    logic [4:0] disp_dst = '0, disp_srca = '0, disp_srcb = '0, disp_srcc = '0;
    logic       disp_ready, wb_valid;
    logic [4:0] wb_dst;
    logic [2:0] wb_cls;

    fpq_issue_ctl u0 (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_cls(disp_cls),
        .disp_dst(disp_dst), .disp_srca(disp_srca), .disp_srcb(disp_srcb),
        .disp_srcc(disp_srcc), .disp_ready(disp_ready), .wb_valid(wb_valid),
        .wb_dst(wb_dst), .wb_cls(wb_cls)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    int cur = 0;
    bit m_busy [32];
    bit m_occ  [64];
    bit m_sv   [64];
    int m_sd   [64];
    int m_sc   [64];
    bit s_ready, s_wb;
    int s_wcls;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cur);
        end
    endtask

    function automatic int ncls(input int c);
        return (c > 4) ? 0 : c;
    endfunction
    function automatic int lat_of(input int c);
        return (ncls(c) == 1) ? 2 : 5;
    endfunction
    function automatic int occ_of(input int c);
        return (ncls(c) == 3) ? 13 : (ncls(c) == 4) ? 25 : 1;
    endfunction
    function automatic string wb_tag(input int c);
        case (c)
            1: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R2";
        endcase
    endfunction

    // One cycle: drive, compare against model, advance model.
    task automatic step(input bit v, input int c, input int d, input int a, input int b, input int x);
        bit src_b, dst_b, win_b, exp_rdy;
        int s, L, O;
        disp_valid = v; disp_cls = 3'(c); disp_dst = 5'(d);
        disp_srca = 5'(a); disp_srcb = 5'(b); disp_srcc = 5'(x);
        #1;
        L = lat_of(c); O = occ_of(c);
        src_b = m_busy[a] || m_busy[b] || (ncls(c) == 2 && m_busy[x]);
        dst_b = m_busy[d];
        win_b = 1'b0;
        for (int k = 0; k < O; k++) if (m_occ[(cur + L + k) % 64]) win_b = 1'b1;
        exp_rdy = !src_b && !dst_b && !win_b;
        chk(disp_ready == exp_rdy, win_b ? "R9" : dst_b ? "R7" : src_b ? "R6" : "R8",
            int'(disp_ready), int'(exp_rdy));
        s = cur % 64;
        chk(wb_valid == m_sv[s], m_sv[s] ? wb_tag(m_sc[s]) : "R11", int'(wb_valid), int'(m_sv[s]));
        if (m_sv[s] && wb_valid) begin
            chk(int'(wb_dst) == m_sd[s], wb_tag(m_sc[s]), int'(wb_dst), m_sd[s]);
            chk(int'(wb_cls) == m_sc[s], (m_sc[s] == 0) ? "R10" : wb_tag(m_sc[s]), int'(wb_cls), m_sc[s]);
        end
        s_ready = disp_ready; s_wb = wb_valid; s_wcls = int'(wb_cls);
        if (m_sv[s]) m_busy[m_sd[s]] = 1'b0;
        m_sv[s] = 1'b0; m_occ[s] = 1'b0;
        if (v && exp_rdy) begin
            m_busy[d] = 1'b1;
            for (int k = 0; k < O; k++) m_occ[(cur + L + k) % 64] = 1'b1;
            s = (cur + L + O - 1) % 64;
            m_sv[s] = 1'b1; m_sd[s] = d; m_sc[s] = ncls(c);
        end
        cur++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 31, 31, 31, 31);
    endtask

    task automatic issue(input int c, input int d, input int a, input int b, input int x);
        for (int i = 0; i < 60; i++) begin
            step(1'b1, c, d, a, b, x);
            if (s_ready) break;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cur, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_busy[i] = 1'b0;
        for (int i = 0; i < 64; i++) begin m_occ[i] = 0; m_sv[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(disp_ready == 1'b1, "R1", int'(disp_ready), 1);
        chk(wb_valid == 1'b0, "R1", int'(wb_valid), 0);

        // R2: plain arithmetic and multiply-add timing
        step(1, 0, 1, 2, 3, 4);
        step(1, 2, 2, 5, 6, 7);
        idle(8);
        // R3 and R9: compare three cycles after arithmetic collides
        step(1, 0, 4, 0, 0, 0);
        idle(2);
        step(1, 1, 5, 0, 0, 0);
        chk(s_ready == 1'b0, "R9", int'(s_ready), 0);
        issue(1, 5, 0, 0, 0);
        idle(8);
        // R6: third source ignored unless multiply-add
        step(1, 0, 7, 0, 0, 0);
        step(1, 0, 9, 1, 2, 7);
        chk(s_ready == 1'b1, "R6", int'(s_ready), 1);
        step(1, 2, 8, 1, 2, 7);
        chk(s_ready == 1'b0, "R6", int'(s_ready), 0);
        issue(2, 8, 1, 2, 7);
        idle(8);
        // R7: pending destination
        step(1, 0, 12, 0, 0, 0);
        step(1, 0, 12, 0, 0, 0);
        chk(s_ready == 1'b0, "R7", int'(s_ready), 0);
        idle(8);
        // R8: reader of a register in its writeback cycle waits one cycle
        step(1, 0, 3, 0, 0, 0);
        idle(4);
        step(1, 0, 13, 3, 0, 0);
        chk(s_wb == 1'b1 && s_ready == 1'b0, "R8", int'(s_ready), 0);
        step(1, 0, 13, 3, 0, 0);
        chk(s_ready == 1'b1, "R8", int'(s_ready), 1);
        idle(8);
        // R4 / R5: divides block followers from writeback
        step(1, 3, 10, 0, 0, 0);
        issue(0, 11, 0, 0, 0);
        idle(34);
        step(1, 4, 14, 0, 0, 0);
        issue(1, 15, 0, 0, 0);
        issue(3, 16, 0, 0, 0);
        idle(50);
        // R10: unused class code acts as arithmetic
        step(1, 6, 17, 0, 0, 0);
        idle(4);
        step(0, 0, 31, 31, 31, 31);
        chk(s_wb == 1'b1 && s_wcls == 0, "R10", s_wcls, 0);
        // R11: request fields without valid
        step(0, 0, 18, 0, 0, 0);
        idle(8);
        chk(s_wb == 1'b0, "R11", int'(s_wb), 0);

        // Mixed random traffic on a small register set
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
        end
        idle(40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule